// File: doc/BRIEF.md
# MPU Region Register Interface

This block is the software-visible register bank of a memory protection unit with a parameterised number of regions. A 32-bit word port with a word offset reaches a control word, a region selector, and a base word and an attribute word that always act on whichever region the selector points at. Three further base/attribute pairs are aliases of the first pair and act on the same selected region.

Each region's base address, enable, size, subregion-disable mask, access permission code and no-execute flag are kept in flip-flops. They are driven out as flat vectors, region k in slice k, to a separate permission checker. A base write may carry its own region index, which moves the selector in the same cycle. Selector writes that name a region the unit does not have are ignored, and so are base writes that carry one.

Top module: `mpu_region_regs`

## Requirements
- R1: While reset is low, and after it is released, the control word, the region selector and every region's base, attribute and permission fields are zero.
- R2: The control word at byte offset 0xD94 (word offset 0x365) keeps write bits [2:0]: bit 0 drives `mpu_on_o`, bit 1 drives `fault_bypass_o` and bit 2 drives `priv_default_o`. Reads return these three bits with all other bits zero. Only a write to this offset changes it.
- R3: The selector at byte offset 0xD98 takes the written value only when the whole 32-bit value is below `N_RGN`. Any other written value is dropped and the old index is kept. A read returns the index zero-extended.
- R4: The base word at 0xD9C and the attribute word at 0xDA0 act on the selected region. A base read returns the stored address bits [31:5] with bits [4:0] zero. Region k appears in slice k of every per-region output.
- R5: The alias pairs at byte offsets 0xDA4/0xDA8, 0xDAC/0xDB0 and 0xDB4/0xDB8 read and write exactly the same base and attribute state as 0xD9C/0xDA0.
- R6: A base write with bit 4 set carries a region index in bits [3:0]. If that index is below `N_RGN`, it is loaded into the selector and the base of that region is written in the same cycle. If it is not, the selector and every base stay unchanged.
- R7: A base write with bit 4 clear updates the currently selected region and leaves the selector unchanged. Bits [3:0] are then ignored.
- R8: Attribute layout: enable bit 0, size [5:1], subregion disables [15:8], permission code [26:24], no-execute bit 28. All other bits are dropped on write and read as zero, so a readback equals the written value AND 0x1700FF3F.
- R9: Any offset other than 0xD94..0xDB8 reads as zero and writes to it change no state. `rd_data` is zero while `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for one word |
| rd_en | input | 1 | Read strobe; `rd_data` is valid in the same cycle |
| addr | input | 10 | Word offset (byte offset bits [11:2]) |
| wdata | input | 32 | Write data |
| rd_data | output | 32 | Read data, combinational from `addr` and the stored state |
| mpu_on_o | output | 1 | Control bit 0 |
| fault_bypass_o | output | 1 | Control bit 1 |
| priv_default_o | output | 1 | Control bit 2 |
| rgn_base_o | output | N_RGN*27 | Per-region base address bits [31:5] |
| rgn_en_o | output | N_RGN | Per-region enable |
| rgn_size_o | output | N_RGN*5 | Per-region size code |
| rgn_srd_o | output | N_RGN*8 | Per-region subregion-disable mask |
| rgn_ap_o | output | N_RGN*3 | Per-region permission code |
| rgn_xn_o | output | N_RGN | Per-region no-execute flag |

## Verification
Base writes are tried in three forms: carried index in range, carried index out of range, and no carried index with junk in the low bits. Together these show whether the selector moves or the write is dropped, and which region's slice changes. Selector writes use a legal value, the value equal to the region count and a large value with small low bits, which exposes a compare done on truncated bits. Attribute writes of all ones and a sparse pattern, made through the primary pair and through aliases, separate correct field packing from alias or mask errors. Unlisted offsets around the window are written with all ones and then read back, together with the live registers, to show that nothing leaked.

// File: rtl/mpu_regs_pkg.sv
package mpu_regs_pkg;
   localparam int OFS_W = 10;
   localparam logic [OFS_W-1:0] OFS_CTRL  = 10'h365;
   localparam logic [OFS_W-1:0] OFS_RNUM  = 10'h366;
   localparam logic [OFS_W-1:0] OFS_BASE0 = 10'h367;
   localparam logic [OFS_W-1:0] OFS_ATTR0 = 10'h368;
   localparam int MAX_ALIAS = 3;

   localparam int BASE_LSB  = 5;
   localparam int BASE_W    = 32 - BASE_LSB;
   localparam int VALID_BIT = 4;
   localparam int CARRY_W   = 4;

   localparam int SIZE_W  = 5;
   localparam int SRD_W   = 8;
   localparam int AP_W    = 3;
   localparam int SZEN_W  = 1 + SIZE_W + SRD_W;
   localparam int ACC_W   = AP_W + 1;
   localparam int CTRL_W  = 3;

   // size/enable store: {srd, size, en}
   function automatic logic [SZEN_W-1:0] szen_from_word(logic [31:0] w);
      return {w[15:8], w[5:1], w[0]};
   endfunction

   // access store: {xn, ap}
   function automatic logic [ACC_W-1:0] acc_from_word(logic [31:0] w);
      return {w[28], w[26:24]};
   endfunction

   function automatic logic [31:0] attr_word(logic [SZEN_W-1:0] s, logic [ACC_W-1:0] a);
      logic [31:0] w;
      w        = '0;
      w[0]     = s[0];
      w[5:1]   = s[5:1];
      w[15:8]  = s[13:6];
      w[26:24] = a[2:0];
      w[28]    = a[3];
      return w;
   endfunction
endpackage

// File: rtl/mpu_addr_dec.sv
module mpu_addr_dec
   import mpu_regs_pkg::*;
#(
   parameter int N_ALIAS = 3
) (
   input  logic [OFS_W-1:0] addr,
   output logic             hit_ctrl,
   output logic             hit_rnum,
   output logic             hit_base,
   output logic             hit_attr
);
   localparam int N_WIN = N_ALIAS + 1;

   logic [N_WIN-1:0] base_hits;
   logic [N_WIN-1:0] attr_hits;

   for (genvar k = 0; k < N_WIN; k++) begin : g_win
      assign base_hits[k] = (addr == OFS_BASE0 + OFS_W'(2 * k));
      assign attr_hits[k] = (addr == OFS_ATTR0 + OFS_W'(2 * k));
   end

   assign hit_ctrl = (addr == OFS_CTRL);
   assign hit_rnum = (addr == OFS_RNUM);
   assign hit_base = |base_hits;
   assign hit_attr = |attr_hits;
endmodule

// File: rtl/mpu_rgn_sel.sv
module mpu_rgn_sel
   import mpu_regs_pkg::*;
#(
   parameter int N_RGN = 8,
   parameter int SEL_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rnum_we,
   input  logic             base_we,
   input  logic [31:0]      wdata,
   output logic [SEL_W-1:0] sel_q,
   output logic             sel_ok,
   output logic             base_go,
   output logic [SEL_W-1:0] base_tgt
);
   logic               carry;
   logic [CARRY_W-1:0] cidx;
   logic               rnum_ok;
   logic               cidx_ok;

   assign carry   = wdata[VALID_BIT];
   assign cidx    = wdata[CARRY_W-1:0];
   assign rnum_ok = (wdata < 32'(N_RGN));
   assign cidx_ok = (32'(cidx) < 32'(N_RGN));
   assign sel_ok  = (32'(sel_q) < 32'(N_RGN));

   assign base_go  = base_we && (carry ? cidx_ok : sel_ok);
   assign base_tgt = carry ? cidx[SEL_W-1:0] : sel_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sel_q <= '0;
      end else if (rnum_we && rnum_ok) begin
         sel_q <= wdata[SEL_W-1:0];
      end else if (base_we && carry && cidx_ok) begin
         sel_q <= cidx[SEL_W-1:0];
      end
   end
endmodule

// File: rtl/mpu_rgn_slot.sv
module mpu_rgn_slot
   import mpu_regs_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              base_we,
   input  logic              attr_we,
   input  logic [BASE_W-1:0] base_d,
   input  logic [SZEN_W-1:0] szen_d,
   input  logic [ACC_W-1:0]  acc_d,
   output logic [BASE_W-1:0] base_q,
   output logic [SZEN_W-1:0] szen_q,
   output logic [ACC_W-1:0]  acc_q
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         base_q <= '0;
         szen_q <= '0;
         acc_q  <= '0;
      end else begin
         if (base_we) base_q <= base_d;
         if (attr_we) begin
            szen_q <= szen_d;
            acc_q  <= acc_d;
         end
      end
   end
endmodule

// File: rtl/mpu_region_regs.sv
module mpu_region_regs
   import mpu_regs_pkg::*;
#(
   parameter int N_RGN   = 8,
   parameter int N_ALIAS = 3
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    wr_en,
   input  logic                    rd_en,
   input  logic [9:0]              addr,
   input  logic [31:0]             wdata,
   output logic [31:0]             rd_data,
   output logic                    mpu_on_o,
   output logic                    fault_bypass_o,
   output logic                    priv_default_o,
   output logic [N_RGN*27-1:0]     rgn_base_o,
   output logic [N_RGN-1:0]        rgn_en_o,
   output logic [N_RGN*5-1:0]      rgn_size_o,
   output logic [N_RGN*8-1:0]      rgn_srd_o,
   output logic [N_RGN*3-1:0]      rgn_ap_o,
   output logic [N_RGN-1:0]        rgn_xn_o
);
   localparam int SEL_W = (N_RGN > 1) ? $clog2(N_RGN) : 1;

   if (N_RGN < 1 || N_RGN > 16) begin : g_bad_rgn
      $error("N_RGN must lie in 1..16 (carried index is 4 bits)");
   end
   if (N_ALIAS < 0 || N_ALIAS > MAX_ALIAS) begin : g_bad_alias
      $error("N_ALIAS must lie in 0..3");
   end

   logic hit_ctrl, hit_rnum, hit_base, hit_attr;
   logic [SEL_W-1:0] sel_q;
   logic [SEL_W-1:0] base_tgt;
   logic sel_ok, base_go, attr_go;
   logic [CTRL_W-1:0] ctrl_q;

   logic [BASE_W-1:0] base_a [N_RGN];
   logic [SZEN_W-1:0] szen_a [N_RGN];
   logic [ACC_W-1:0]  acc_a  [N_RGN];

   mpu_addr_dec #(.N_ALIAS(N_ALIAS)) u_dec (
      .addr     (addr),
      .hit_ctrl (hit_ctrl),
      .hit_rnum (hit_rnum),
      .hit_base (hit_base),
      .hit_attr (hit_attr)
   );

   mpu_rgn_sel #(.N_RGN(N_RGN), .SEL_W(SEL_W)) u_sel (
      .clk      (clk),
      .rst_n    (rst_n),
      .rnum_we  (wr_en && hit_rnum),
      .base_we  (wr_en && hit_base),
      .wdata    (wdata),
      .sel_q    (sel_q),
      .sel_ok   (sel_ok),
      .base_go  (base_go),
      .base_tgt (base_tgt)
   );

   assign attr_go = wr_en && hit_attr && sel_ok;

   for (genvar k = 0; k < N_RGN; k++) begin : g_slot
      mpu_rgn_slot u_slot (
         .clk     (clk),
         .rst_n   (rst_n),
         .base_we (base_go && (base_tgt == SEL_W'(k))),
         .attr_we (attr_go && (sel_q == SEL_W'(k))),
         .base_d  (wdata[31:BASE_LSB]),
         .szen_d  (szen_from_word(wdata)),
         .acc_d   (acc_from_word(wdata)),
         .base_q  (base_a[k]),
         .szen_q  (szen_a[k]),
         .acc_q   (acc_a[k])
      );
      assign rgn_base_o[k*BASE_W +: BASE_W] = base_a[k];
      assign rgn_en_o[k]                    = szen_a[k][0];
      assign rgn_size_o[k*SIZE_W +: SIZE_W] = szen_a[k][5:1];
      assign rgn_srd_o[k*SRD_W +: SRD_W]    = szen_a[k][13:6];
      assign rgn_ap_o[k*AP_W +: AP_W]       = acc_a[k][2:0];
      assign rgn_xn_o[k]                    = acc_a[k][3];
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                   ctrl_q <= '0;
      else if (wr_en && hit_ctrl)   ctrl_q <= wdata[CTRL_W-1:0];
   end

   assign mpu_on_o       = ctrl_q[0];
   assign fault_bypass_o = ctrl_q[1];
   assign priv_default_o = ctrl_q[2];

   logic [31:0] rd_mux;
   always_comb begin
      rd_mux = '0;
      if (hit_ctrl)                rd_mux = 32'(ctrl_q);
      else if (hit_rnum)           rd_mux = 32'(sel_q);
      else if (hit_base && sel_ok) rd_mux = {base_a[sel_q], {BASE_LSB{1'b0}}};
      else if (hit_attr && sel_ok) rd_mux = attr_word(szen_a[sel_q], acc_a[sel_q]);
   end

   assign rd_data = rd_en ? rd_mux : '0;
endmodule

// File: rtl/mpu_regs_chk.sv
module mpu_regs_chk
   import mpu_regs_pkg::*;
#(
   parameter int N_RGN   = 8,
   parameter int N_ALIAS = 3,
   parameter int SEL_W   = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic              rd_en,
   input logic [9:0]        addr,
   input logic [31:0]       wdata,
   input logic [31:0]       rd_data,
   input logic [SEL_W-1:0]  sel_q,
   input logic              mpu_on_o,
   input logic              fault_bypass_o,
   input logic              priv_default_o,
   input logic [N_RGN-1:0]  rgn_en_o
);
   logic [2:0] ctrl_v;
   logic       listed;
   assign ctrl_v = {priv_default_o, fault_bypass_o, mpu_on_o};
   assign listed = (addr >= OFS_CTRL) && (addr <= OFS_ATTR0 + 10'(2 * N_ALIAS));

   // R1: state is clear on the first cycle out of reset
   a_r1_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (sel_q == '0 && ctrl_v == 3'b000 && rgn_en_o == '0));

   // R2: control bits move only on a control write
   a_r2_ctrl_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && addr == OFS_CTRL) |=> $stable(ctrl_v));

   // R3: an out-of-range selector write leaves the index alone
   a_r3_rnum_ignore: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == OFS_RNUM && wdata >= 32'(N_RGN)) |=> $stable(sel_q));

   // R6: a carried in-range index lands in the selector
   a_r6_carry_load: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == OFS_BASE0 && wdata[VALID_BIT] && 32'(wdata[3:0]) < 32'(N_RGN))
      |=> (32'(sel_q) == 32'($past(wdata[3:0]))));

   // R7: a base write without carried index keeps the selector
   a_r7_plain_base_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == OFS_BASE0 && !wdata[VALID_BIT]) |=> $stable(sel_q));

   // R9: unlisted offsets and idle reads give zero
   a_r9_unlisted_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_en || !listed) |-> (rd_data == 32'h0));
endmodule

bind mpu_region_regs mpu_regs_chk #(.N_RGN(N_RGN), .N_ALIAS(N_ALIAS), .SEL_W(SEL_W)) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .wr_en          (wr_en),
   .rd_en          (rd_en),
   .addr           (addr),
   .wdata          (wdata),
   .rd_data        (rd_data),
   .sel_q          (sel_q),
   .mpu_on_o       (mpu_on_o),
   .fault_bypass_o (fault_bypass_o),
   .priv_default_o (priv_default_o),
   .rgn_en_o       (rgn_en_o)
);

// File: tb/sim_mpu_region_regs.sv
module sim_mpu_region_regs;
   localparam int N = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wr_en = 1'b0;
   logic rd_en = 1'b0;
   logic [9:0] addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rd_data;
   logic mpu_on_o, fault_bypass_o, priv_default_o;
   logic [N*27-1:0] rgn_base_o;
   logic [N-1:0]    rgn_en_o;
   logic [N*5-1:0]  rgn_size_o;
   logic [N*8-1:0]  rgn_srd_o;
   logic [N*3-1:0]  rgn_ap_o;
   logic [N-1:0]    rgn_xn_o;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   typedef struct { logic [31:0] exp; string tag; } item_t;
   item_t sb[$];

   always #10 clk = ~clk;

   mpu_region_regs #(.N_RGN(N), .N_ALIAS(3)) u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
      .wdata(wdata), .rd_data(rd_data), .mpu_on_o(mpu_on_o),
      .fault_bypass_o(fault_bypass_o), .priv_default_o(priv_default_o),
      .rgn_base_o(rgn_base_o), .rgn_en_o(rgn_en_o), .rgn_size_o(rgn_size_o),
      .rgn_srd_o(rgn_srd_o), .rgn_ap_o(rgn_ap_o), .rgn_xn_o(rgn_xn_o)
   );

   task automatic chk(logic [31:0] got, logic [31:0] exp, string tag);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %08h expected %08h", tag, got, exp);
      end
   endtask

   // monitor: compare read data against scoreboard in mid-cycle
   always @(negedge clk) begin
      if (rd_en === 1'b1) begin
         if (sb.size() == 0) begin
            chk(rd_data, 32'hDEADBEEF, "scoreboard empty");
         end else begin
            item_t it;
            it = sb.pop_front();
            chk(rd_data, it.exp, it.tag);
         end
      end
   end

   task automatic wr(logic [11:0] ofs, logic [31:0] d);
      wr_en = 1'b1; rd_en = 1'b0; addr = ofs[11:2]; wdata = d;
      @(posedge clk); #1;
      wr_en = 1'b0;
   endtask

   task automatic rd(logic [11:0] ofs, logic [31:0] exp, string tag);
      item_t it;
      it.exp = exp; it.tag = tag;
      sb.push_back(it);
      rd_en = 1'b1; wr_en = 1'b0; addr = ofs[11:2]; wdata = '0;
      @(posedge clk); #1;
      rd_en = 1'b0;
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (2) @(posedge clk);
      #1 rst_n = 1'b1;
   endtask

   function automatic logic [31:0] attr_exp(logic [31:0] w);
      return w & 32'h1700FF3F;
   endfunction

   initial begin
      @(posedge clk); #1;
      do_reset();

      // R1 reset state
      rd(12'hD94, 32'h0, "R1 ctrl after reset");
      rd(12'hD98, 32'h0, "R1 selector after reset");
      rd(12'hD9C, 32'h0, "R1 base after reset");
      rd(12'hDA0, 32'h0, "R1 attr after reset");
      chk(32'(rgn_en_o), 32'h0, "R1 enables after reset");
      chk(32'(rgn_base_o[5*27 +: 27]), 32'h0, "R1 base port after reset");

      // R2 control word
      wr(12'hD94, 32'hFFFF_FFFF);
      rd(12'hD94, 32'h7, "R2 ctrl all ones");
      chk({29'h0, priv_default_o, fault_bypass_o, mpu_on_o}, 32'h7, "R2 ctrl ports");
      wr(12'hD94, 32'h5);
      chk({29'h0, priv_default_o, fault_bypass_o, mpu_on_o}, 32'h5, "R2 ctrl ports 101");

      // R3 selector
      wr(12'hD98, 32'd5);
      rd(12'hD98, 32'd5, "R3 legal selector");
      wr(12'hD98, 32'd8);
      rd(12'hD98, 32'd5, "R3 selector equal to count dropped");
      wr(12'hD98, 32'hFFFF_FFF3);
      rd(12'hD98, 32'd5, "R3 large selector dropped");

      // R4 primary base, R8 attribute packing
      wr(12'hD9C, 32'h2000_0000);
      rd(12'hD9C, 32'h2000_0000, "R4 base readback");
      chk(32'(rgn_base_o[5*27 +: 27]), 32'h2000_0000 >> 5, "R4 base port slice 5");
      wr(12'hDA0, 32'hFFFF_FFFF);
      rd(12'hDA0, attr_exp(32'hFFFF_FFFF), "R8 attr all ones");
      chk({27'h0, rgn_size_o[25 +: 5]}, 32'h1F, "R8 size port");
      chk({24'h0, rgn_srd_o[40 +: 8]}, 32'hFF, "R8 srd port");
      chk({29'h0, rgn_ap_o[15 +: 3]}, 32'h7, "R8 ap port");
      chk({30'h0, rgn_xn_o[5], rgn_en_o[5]}, 32'h3, "R8 xn/en ports");

      // R5 aliases
      rd(12'hDA4, 32'h2000_0000, "R5 alias1 base read");
      wr(12'hDAC, 32'h3000_0000);
      rd(12'hD9C, 32'h3000_0000, "R5 alias2 base write");
      wr(12'hDB8, 32'h0300_0A03);
      rd(12'hDA8, 32'h0300_0A03, "R5 alias3 attr write alias1 read");
      rd(12'hDB0, 32'h0300_0A03, "R5 alias2 attr read");
      chk({rgn_xn_o[5], rgn_en_o[5], 25'h0, rgn_size_o[25 +: 5]}, 32'h4000_0001, "R5 ports after alias");

      // R6 carried index
      wr(12'hD9C, 32'h4000_0012);
      rd(12'hD98, 32'd2, "R6 carried index loads selector");
      rd(12'hD9C, 32'h4000_0000, "R6 carried base written");
      chk(32'(rgn_base_o[5*27 +: 27]), 32'h3000_0000 >> 5, "R6 other region untouched");
      wr(12'hD9C, 32'h8000_0019);
      rd(12'hD98, 32'd2, "R6 out-of-range carried keeps selector");
      chk(32'(rgn_base_o[2*27 +: 27]), 32'h4000_0000 >> 5, "R6 out-of-range carried drops base");
      chk(32'(rgn_base_o[1*27 +: 27]), 32'h0, "R6 region1 untouched");

      // R7 plain base write
      wr(12'hD9C, 32'h6000_000F);
      rd(12'hD98, 32'd2, "R7 selector kept");
      rd(12'hD9C, 32'h6000_0000, "R7 base of selected region");
      wr(12'hDA0, 32'h1000_0001);
      rd(12'hDA0, 32'h1000_0001, "R8 sparse attr");

      // R9 unlisted offsets
      wr(12'hD90, 32'hFFFF_FFFF);
      wr(12'hDBC, 32'hFFFF_FFFF);
      wr(12'h000, 32'hFFFF_FFFF);
      rd(12'hD90, 32'h0, "R9 read below window");
      rd(12'hDBC, 32'h0, "R9 read above window");
      rd(12'h000, 32'h0, "R9 read offset zero");
      rd(12'hD98, 32'd2, "R9 selector unchanged");
      rd(12'hD94, 32'h5, "R9 ctrl unchanged");
      rd(12'hD9C, 32'h6000_0000, "R9 base unchanged");
      rd(12'hDA0, 32'h1000_0001, "R9 attr unchanged");
      addr = 10'h365;
      #2 chk(rd_data, 32'h0, "R9 idle read gives zero");

      // R1 reset mid-run
      do_reset();
      rd(12'hD98, 32'h0, "R1 selector after second reset");
      rd(12'hD94, 32'h0, "R1 ctrl after second reset");
      rd(12'hD9C, 32'h0, "R1 base after second reset");
      chk(32'(rgn_en_o), 32'h0, "R1 enables after second reset");
      chk(32'(rgn_base_o[2*27 +: 27]), 32'h0, "R1 region2 base cleared");
      chk(32'(rgn_xn_o), 32'h0, "R1 xn cleared");

      @(posedge clk); #1;
      if (sb.size() != 0) chk(32'(sb.size()), 32'h0, "scoreboard drained");
      done = 1'b1;
      $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      #(200000 * 20);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end
endmodule